// File: doc/BRIEF.md
# Flash Block Write Protection Gate

This block decides, request by request, whether a program or erase aimed at a byte address of a 512 KB flash array may go ahead. The array is split into eight uniform 64 KB blocks (each made of 4 KB sectors). The block holds one small lock register per 64 KB block. The registers are read and written through a simple register port. Their contents are combined with two active-low protection pins: one guards only the highest block, the other guards every block below it.

The surrounding command decoder presents a request address with `reqValid` and receives either `reqAllow` or `reqReject` in the same cycle. Software uses the register port to set a write-lock bit per block. It can also set a lock-down bit, which freezes that block's settings until the next reset.

Top module: `flash_block_protect`

## Requirements
- R1: After reset (`rstN` low), every lock register reads 00h, so with both pins high every request is allowed.
- R2: Register readback is combinational on `regAddr`: bit 0 is the write-lock, bit 1 is the lock-down, and bits [7:2] always read as zero, even after a write of ones.
- R3: Register index k governs block `NUM_BLOCKS-1-k`, where the block number is `reqAddr[18:16]`. Index 0 is therefore the top block (addresses 70000h to 7FFFFh).
- R4: A write-lock bit of 1 rejects requests to its block and has no effect on any other block.
- R5: Once a register's lock-down bit is 1, writes to that register leave bits [1:0] unchanged until reset.
- R6: With `topLockN` low, requests to the top block are rejected, and requests to the other blocks are unaffected by this pin.
- R7: With `protectN` low, requests to every block except the top block are rejected, and the top block is unaffected by this pin.
- R8: A request is allowed only when both the pin for its block and the register for its block permit it. With `reqValid` high exactly one of `reqAllow` and `reqReject` is high; with `reqValid` low both are low.
- R9: A register write issued in one cycle changes the readback and the gating decision from the next clock edge on, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register readback at `regAddr` |
| reqValid | input | 1 | Program/erase request present |
| reqAddr | input | 19 | Byte address of the request |
| topLockN | input | 1 | Active-low protection pin for the top block |
| protectN | input | 1 | Active-low protection pin for all other blocks |
| reqAllow | output | 1 | Request may proceed |
| reqReject | output | 1 | Request is refused |

## Verification
The bench targets the reversed index order between registers and blocks: a design that maps index k straight to block k would lock the bottom block when software meant to lock the top one. It tests the boundary between the top block and the one below it under each pin, which catches a swapped or widened pin scope. It then tries to clear a locked-down register and expects the lock to survive; a design with a non-sticky lock-down would unlock the block. A final probe samples the readback just before and just after the write edge, which exposes a register that is updated combinationally.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  // Strobes from control to the lock register datapath.
  typedef struct packed {
    logic load;     // write selected registers this cycle
    logic lockVal;  // new write-lock value
    logic downVal;  // new lock-down value
  } protStrb_t;
endpackage

// File: rtl/prot_regs.sv
module prot_regs
  import flash_prot_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 8,
  parameter int unsigned REG_W      = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  protStrb_t             strb,
  input  logic [NUM_BLOCKS-1:0] wrSel,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [REG_W-1:0]      rdData,
  output logic [NUM_BLOCKS-1:0] lockVec,
  output logic [NUM_BLOCKS-1:0] downVec
);
  for (genvar k = 0; k < NUM_BLOCKS; k++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockVec[k] <= 1'b0;
        downVec[k] <= 1'b0;
      end else if (strb.load && wrSel[k]) begin
        lockVec[k] <= strb.lockVal;
        downVec[k] <= strb.downVal;
      end
    end
  end

  always_comb begin
    rdData    = '0;
    rdData[0] = lockVec[rdIdx];
    rdData[1] = downVec[rdIdx];
  end
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS  = 8,
  parameter int unsigned BLOCK_OFS_W = 16,
  parameter int unsigned REG_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_BLOCKS),
  localparam int unsigned ADDR_W     = BLOCK_OFS_W + IDX_W
) (
  input  logic                  regWrEn,
  input  logic [IDX_W-1:0]      regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [NUM_BLOCKS-1:0] lockVec,
  input  logic [NUM_BLOCKS-1:0] downVec,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  topLockN,
  input  logic                  protectN,
  output protStrb_t             strb,
  output logic [NUM_BLOCKS-1:0] wrSel,
  output logic                  reqAllow,
  output logic                  reqReject
);
  localparam logic [IDX_W-1:0] TOP_BLK = IDX_W'(NUM_BLOCKS - 1);

  logic [IDX_W-1:0] blkNum;
  logic [IDX_W-1:0] regIdx;
  logic             isTop;
  logic             pinBlocked;
  logic             swBlocked;
  logic             unusedBits;

  assign strb.load    = regWrEn;
  assign strb.lockVal = regWrData[0];
  assign strb.downVal = regWrData[1];
  assign unusedBits   = ^{regWrData[REG_W-1:2], reqAddr[BLOCK_OFS_W-1:0]};

  // A register frozen by its lock-down bit never gets a write select.
  for (genvar k = 0; k < NUM_BLOCKS; k++) begin : gSel
    assign wrSel[k] = (regAddr == IDX_W'(k)) && !downVec[k];
  end

  // Register index counts down from the top block.
  assign blkNum     = reqAddr[ADDR_W-1 -: IDX_W];
  assign regIdx     = TOP_BLK - blkNum;
  assign isTop      = (blkNum == TOP_BLK);
  assign pinBlocked = isTop ? !topLockN : !protectN;
  assign swBlocked  = lockVec[regIdx];

  assign reqAllow  = reqValid && !pinBlocked && !swBlocked;
  assign reqReject = reqValid && (pinBlocked || swBlocked);
endmodule

// File: rtl/flash_block_protect.sv
module flash_block_protect
  import flash_prot_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS  = 8,
  parameter int unsigned BLOCK_OFS_W = 16,
  parameter int unsigned REG_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_BLOCKS),
  localparam int unsigned ADDR_W     = BLOCK_OFS_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              topLockN,
  input  logic              protectN,
  output logic              reqAllow,
  output logic              reqReject
);
  protStrb_t             strb;
  logic [NUM_BLOCKS-1:0] wrSel;
  logic [NUM_BLOCKS-1:0] lockVec;
  logic [NUM_BLOCKS-1:0] downVec;

  prot_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_OFS_W(BLOCK_OFS_W), .REG_W(REG_W)) uCtrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .lockVec(lockVec), .downVec(downVec),
    .reqValid(reqValid), .reqAddr(reqAddr),
    .topLockN(topLockN), .protectN(protectN),
    .strb(strb), .wrSel(wrSel),
    .reqAllow(reqAllow), .reqReject(reqReject)
  );

  prot_regs #(.NUM_BLOCKS(NUM_BLOCKS), .REG_W(REG_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSel(wrSel),
    .rdIdx(regAddr), .rdData(regRdData),
    .lockVec(lockVec), .downVec(downVec)
  );
endmodule

// File: rtl/flash_block_protect_chk.sv
module flash_block_protect_chk #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned REG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [IDX_W-1:0]  regAddr,
  input logic [REG_W-1:0]  regRdData,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              topLockN,
  input logic              protectN,
  input logic              reqAllow,
  input logic              reqReject
);
  logic atTop;
  assign atTop = &reqAddr[ADDR_W-1 -: IDX_W];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:2] == '0); // R2

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({reqAllow, reqReject}) == 1); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !reqAllow && !reqReject); // R8

  AST_TOP_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && atTop && !topLockN) |-> reqReject); // R6

  AST_LOW_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !atTop && !protectN) |-> reqReject); // R7

  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRdData[1]) && $stable(regAddr)) |-> $stable(regRdData[1:0])); // R5
endmodule

bind flash_block_protect flash_block_protect_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .reqValid(reqValid), .reqAddr(reqAddr), .topLockN(topLockN),
  .protectN(protectN), .reqAllow(reqAllow), .reqReject(reqReject)
);

// File: tb/tb_flash_block_protect.sv
`timescale 1ns/1ps
module tb_flash_block_protect;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic        reqValid;
  logic [18:0] reqAddr;
  logic        topLockN;
  logic        protectN;
  logic        reqAllow;
  logic        reqReject;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  flash_block_protect dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .topLockN(topLockN), .protectN(protectN),
    .reqAllow(reqAllow), .reqReject(reqReject)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    reqValid = 1'b0; reqAddr = '0; topLockN = 1'b1; protectN = 1'b1;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input string req, input logic [2:0] idx, input logic [7:0] exp);
    regAddr = idx;
    #1;
    check(req, regRdData, exp);
  endtask

  // Expected result: {allow, reject}
  task automatic probe(input string req, input logic [2:0] blk, input logic [1:0] exp);
    reqValid = 1'b1; reqAddr = {blk, 16'h4a5c};
    #1;
    check(req, {6'b0, reqAllow, reqReject}, {6'b0, exp});
    reqValid = 1'b0;
    #1;
  endtask

  localparam logic [1:0] OK = 2'b10;
  localparam logic [1:0] NO = 2'b01;

  task automatic tReset();
    doReset();
    for (int i = 0; i < 8; i++) regRead("R1", 3'(i), 8'h00);
    for (int b = 0; b < 8; b++) probe("R1", 3'(b), OK);
    #1; check("R8", {6'b0, reqAllow, reqReject}, 8'h00);
  endtask

  task automatic tReadback();
    doReset();
    regWrite(3'd3, 8'hFC); regRead("R2", 3'd3, 8'h00);
    regWrite(3'd3, 8'hFD); regRead("R2", 3'd3, 8'h01);
    regWrite(3'd3, 8'h00); regRead("R2", 3'd3, 8'h00);
  endtask

  task automatic tMapping();
    doReset();
    regWrite(3'd0, 8'h01);
    probe("R3", 3'd7, NO);
    probe("R3", 3'd0, OK);
    probe("R4", 3'd6, OK);
    regWrite(3'd7, 8'h01);
    probe("R3", 3'd0, NO);
    regWrite(3'd0, 8'h00);
    probe("R4", 3'd7, OK);
  endtask

  task automatic tLockDown();
    doReset();
    regWrite(3'd2, 8'h03);
    regRead("R5", 3'd2, 8'h03);
    regWrite(3'd2, 8'h00);
    regRead("R5", 3'd2, 8'h03);
    probe("R5", 3'd5, NO);
    regWrite(3'd4, 8'h02);
    regWrite(3'd4, 8'h01);
    regRead("R5", 3'd4, 8'h02);
    probe("R5", 3'd3, OK);
    doReset();
    regRead("R1", 3'd2, 8'h00);
    probe("R1", 3'd5, OK);
  endtask

  task automatic tPins();
    doReset();
    topLockN = 1'b0;
    probe("R6", 3'd7, NO);
    probe("R6", 3'd6, OK);
    probe("R6", 3'd0, OK);
    topLockN = 1'b1; protectN = 1'b0;
    probe("R7", 3'd7, OK);
    probe("R7", 3'd6, NO);
    probe("R7", 3'd0, NO);
    protectN = 1'b1;
  endtask

  task automatic tCombine();
    doReset();
    regWrite(3'd7, 8'h01);
    probe("R8", 3'd0, NO);
    topLockN = 1'b0;
    probe("R8", 3'd0, NO);
    probe("R8", 3'd1, OK);
    topLockN = 1'b1; protectN = 1'b0;
    regWrite(3'd7, 8'h00);
    probe("R8", 3'd0, NO);
    protectN = 1'b1;
    probe("R8", 3'd0, OK);
  endtask

  task automatic tTiming();
    doReset();
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 8'h01;
    #1.5;
    check("R9", regRdData, 8'h00);
    reqValid = 1'b1; reqAddr = {3'd6, 16'h0000};
    #0.5;
    check("R9", {6'b0, reqAllow, reqReject}, {6'b0, OK});
    @(posedge clk); #1;
    regWrEn = 1'b0;
    check("R9", regRdData, 8'h01);
    check("R9", {6'b0, reqAllow, reqReject}, {6'b0, NO});
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    reqValid = 1'b0; reqAddr = '0; topLockN = 1'b1; protectN = 1'b1;
    tReset();
    tReadback();
    tMapping();
    tLockDown();
    tPins();
    tCombine();
    tTiming();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #20000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule